// File: doc/BRIEF.md
# Load/Store-Multiple Address Sequencer

This block carries out one block transfer between a 16-entry register file and memory. A single start pulse supplies a register mask, the base address and the index of the base register. The same pulse carries the direction (load or store), the address direction (up or down), the access timing (pre or post) and whether writeback is wanted. The sequencer then issues one memory request per selected register. Requests go out in ascending register order, one word apart, and each waits on a ready handshake. On stores it reads the register file. On loads it writes the register file in the same cycle the memory accepts the request.

Some cases are special. When the base register is part of the list, the sequencer chooses what to store or whether to suppress writeback. A stored program counter (register 15) gets a fixed offset. An empty mask becomes a single transfer of register 15 and moves the address by sixteen words. When the status-restore flag is set on a load that includes register 15, a strobe is raised as register 15 is written. The cycle after the last accepted request, the sequencer pulses done and presents the updated base.

Top module: `lsm_seq`

## Requirements
- R1: For a non-empty mask, selected registers are transferred in ascending index order, and each accepted request's address is 4 above the previous one.
- R2: The first address is base+4 for up/pre, base for up/post, base-4n for down/pre, and base-4n+4 for down/post, where n is the number of set mask bits.
- R3: At done, wb_valid_o is high when writeback is requested, and wb_value_o is base+4n for up or base-4n for down.
- R4: On a load whose mask contains the base register index, wb_valid_o stays low at done.
- R5: A store of the base register writes the original base if it is the first register transferred, and otherwise writes the step-R3 value.
- R6: A store of register 15 writes pc_i+12.
- R7: An empty mask gives exactly one transfer, of register 15, at the base address. A load writes the read word with bits [1:0] cleared. A store writes pc_i+12. The writeback value is base+64.
- R8: mem_seq_o is 0 on the first request of a block and 1 on each later request.
- R9: psr_restore_o is high exactly in the cycle in which a load with psr_i set writes register 15 named in a non-empty mask. It is low at all other times.
- R10: done_o is a one-cycle pulse, asserted the cycle after the final accepted request, with mem_req_o low.
- R11: While rst_ni is low, busy_o, mem_req_o and done_o are 0.
- R12: While a request waits with mem_ready_i low, mem_req_o stays high and mem_addr_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken while idle |
| reg_list_i | input | 16 | Register mask, bit i selects register i |
| base_i | input | 32 | Base address value |
| base_idx_i | input | 4 | Index of the base register |
| load_i | input | 1 | 1 = load, 0 = store |
| up_i | input | 1 | 1 = addresses go up from base, 0 = down |
| pre_i | input | 1 | 1 = step before access, 0 = after |
| wb_i | input | 1 | Writeback requested |
| psr_i | input | 1 | Status-restore flag |
| pc_i | input | 32 | Address of the transfer instruction |
| busy_o | output | 1 | Block in progress |
| mem_req_o | output | 1 | Memory request |
| mem_addr_o | output | 32 | Request address |
| mem_we_o | output | 1 | Request is a write |
| mem_wdata_o | output | 32 | Write data |
| mem_seq_o | output | 1 | 1 = sequential, 0 = nonsequential |
| mem_ready_i | input | 1 | Memory accepts request this cycle |
| mem_rdata_i | input | 32 | Read data, valid with mem_ready_i |
| rf_raddr_o | output | 4 | Register file read index |
| rf_rdata_i | input | 32 | Register file read data, combinational |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |
| psr_restore_o | output | 1 | Status-restore strobe |
| done_o | output | 1 | Block finished, one cycle |
| wb_valid_o | output | 1 | Writeback of base is due |
| wb_value_o | output | 32 | Updated base value |

## Verification
The assertions check the cycle-level handshake rules on every cycle:
- the 4-byte step between accepted requests;
- the address and request held during a stall;
- the nonsequential-then-sequential tagging;
- the status strobe coinciding with a register 15 write;
- done following the last request as a single pulse, with writeback valid only alongside done.

Some behaviour only the bench's scenarios can show. This covers the absolute start addresses in all four address modes and the register order. It also covers the stored values for the base register and register 15, the empty-mask transfer and its base+64 result, and writeback suppression on loads. The bench checks these against values it computes from the inputs, under random ready stalls.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } lsm_state_t;
endpackage

// File: rtl/lsm_plan.sv
// Start address and final base for a block, from mask size and mode.
module lsm_plan #(
  parameter int NREG = 16,
  parameter int XLEN = 32
) (
  input  logic [NREG-1:0] list_i,
  input  logic [XLEN-1:0] base_i,
  input  logic            up_i,
  input  logic            pre_i,
  output logic [XLEN-1:0] first_addr_o,
  output logic [XLEN-1:0] wb_addr_o,
  output logic            empty_o
);
  localparam int CW = $clog2(NREG + 1);
  localparam logic [XLEN-1:0] EMPTY_STEP = XLEN'(4 * NREG);

  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] span, lo;
  logic            eff_pre;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CW'(list_i[i]);
  end

  assign empty_o = (list_i == '0);
  assign span    = XLEN'(cnt) << 2;
  assign lo      = up_i ? base_i : base_i - span;
  // down modes start at the lowest word, so the step timing flips
  assign eff_pre = pre_i ^ ~up_i;

  assign first_addr_o = empty_o ? base_i : lo + (eff_pre ? XLEN'(4) : '0);
  assign wb_addr_o    = empty_o ? base_i + EMPTY_STEP
                                : (up_i ? base_i + span : base_i - span);
endmodule

// File: rtl/lsm_pick.sv
// Lowest set bit of the remaining mask; empty mask selects the top register.
module lsm_pick #(
  parameter int NREG = 16,
  parameter int IW   = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask_i,
  output logic [IW-1:0]   idx_o,
  output logic            last_o
);
  logic [NREG-1:0] rest;

  always_comb begin
    idx_o = IW'(NREG - 1);
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
  end

  assign rest   = mask_i & (mask_i - 1'b1);
  assign last_o = (rest == '0);
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
  import lsm_pkg::*;
#(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  parameter int IW   = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NREG-1:0] reg_list_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [IW-1:0]   base_idx_i,
  input  logic            load_i,
  input  logic            up_i,
  input  logic            pre_i,
  input  logic            wb_i,
  input  logic            psr_i,
  input  logic [XLEN-1:0] pc_i,
  output logic            busy_o,
  output logic            mem_req_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_wdata_o,
  output logic            mem_seq_o,
  input  logic            mem_ready_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic [IW-1:0]   rf_raddr_o,
  input  logic [XLEN-1:0] rf_rdata_i,
  output logic            rf_we_o,
  output logic [IW-1:0]   rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            psr_restore_o,
  output logic            done_o,
  output logic            wb_valid_o,
  output logic [XLEN-1:0] wb_value_o
);
  localparam logic [IW-1:0]   PC_IDX  = IW'(NREG - 1);
  localparam logic [XLEN-1:0] PC_OFFS = XLEN'(12);

  lsm_state_t      state_q;
  logic [NREG-1:0] rem_q;
  logic [XLEN-1:0] addr_q, base_q, wbv_q, pc_q;
  logic [IW-1:0]   bidx_q;
  logic            load_q, sbit_q, first_q, empty_q, wbok_q;

  logic [XLEN-1:0] plan_first, plan_wb;
  logic            plan_empty;
  logic [IW-1:0]   cur_idx;
  logic            cur_last, hs;
  logic [XLEN-1:0] st_data;

  lsm_plan #(.NREG(NREG), .XLEN(XLEN)) i_plan (
    .list_i      (reg_list_i),
    .base_i      (base_i),
    .up_i        (up_i),
    .pre_i       (pre_i),
    .first_addr_o(plan_first),
    .wb_addr_o   (plan_wb),
    .empty_o     (plan_empty)
  );

  lsm_pick #(.NREG(NREG), .IW(IW)) i_pick (
    .mask_i(rem_q),
    .idx_o (cur_idx),
    .last_o(cur_last)
  );

  assign hs = (state_q == ST_XFER) && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      base_q  <= '0;
      wbv_q   <= '0;
      pc_q    <= '0;
      bidx_q  <= '0;
      load_q  <= 1'b0;
      sbit_q  <= 1'b0;
      first_q <= 1'b0;
      empty_q <= 1'b0;
      wbok_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_XFER;
          rem_q   <= reg_list_i;
          addr_q  <= plan_first;
          base_q  <= base_i;
          wbv_q   <= plan_wb;
          pc_q    <= pc_i;
          bidx_q  <= base_idx_i;
          load_q  <= load_i;
          sbit_q  <= psr_i;
          first_q <= 1'b1;
          empty_q <= plan_empty;
          // a loaded base overrides any writeback
          wbok_q  <= wb_i && !(load_i && reg_list_i[base_idx_i]);
        end
        ST_XFER: if (hs) begin
          rem_q[cur_idx] <= 1'b0;
          addr_q  <= addr_q + XLEN'(4);
          first_q <= 1'b0;
          if (cur_last) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (cur_idx == PC_IDX)      st_data = pc_q + PC_OFFS;
    else if (cur_idx == bidx_q) st_data = first_q ? base_q : wbv_q;
    else                        st_data = rf_rdata_i;
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign mem_req_o     = (state_q == ST_XFER);
  assign mem_addr_o    = addr_q;
  assign mem_we_o      = mem_req_o && !load_q;
  assign mem_wdata_o   = mem_we_o ? st_data : '0;
  assign mem_seq_o     = mem_req_o && !first_q;
  assign rf_raddr_o    = cur_idx;
  assign rf_we_o       = hs && load_q;
  assign rf_waddr_o    = cur_idx;
  assign rf_wdata_o    = empty_q ? {mem_rdata_i[XLEN-1:2], 2'b00} : mem_rdata_i;
  assign psr_restore_o = rf_we_o && sbit_q && !empty_q && (cur_idx == PC_IDX);
  assign done_o        = (state_q == ST_DONE);
  assign wb_valid_o    = done_o && wbok_q;
  assign wb_value_o    = wb_valid_o ? wbv_q : '0;

  p_addr_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && !cur_last |=> mem_addr_o == $past(mem_addr_o) + XLEN'(4));
  p_first_nseq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> !mem_seq_o);
  p_later_seq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && !cur_last |=> mem_seq_o);
  p_restore_pc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psr_restore_o |-> rf_we_o && rf_waddr_o == PC_IDX);
  p_done_after_last_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && cur_last |=> done_o && !mem_req_o);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_wb_with_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> done_o);
  p_stall_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));
endmodule

// File: tb/test_lsm_seq.sv
module test_lsm_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RD_KEY = 32'hC3A5_0F1E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] reg_list = '0;
  logic [31:0] base = '0;
  logic [3:0]  base_idx = '0;
  logic        load = 1'b0, up = 1'b0, pre = 1'b0, wb = 1'b0, psr = 1'b0;
  logic [31:0] pc = '0;
  logic        busy, mem_req, mem_we, mem_seq;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata;
  logic        rf_we, psr_restore, done, wb_valid;
  logic [31:0] wb_value;
  logic [31:0] rf [16];

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem_addr ^ RD_KEY;

  lsm_seq i_lsm_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .reg_list_i(reg_list),
    .base_i(base), .base_idx_i(base_idx), .load_i(load), .up_i(up),
    .pre_i(pre), .wb_i(wb), .psr_i(psr), .pc_i(pc), .busy_o(busy),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_seq_o(mem_seq), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata), .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .psr_restore_o(psr_restore), .done_o(done), .wb_valid_o(wb_valid),
    .wb_value_o(wb_value)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_wb(logic [15:0] l, logic [31:0] b, bit u);
    logic [31:0] span = 32'($countones(l)) << 2;
    if (l == '0) return b + 32'd64;
    return u ? b + span : b - span;
  endfunction

  function automatic logic [31:0] exp_first(logic [15:0] l, logic [31:0] b, bit u, bit p);
    logic [31:0] span = 32'($countones(l)) << 2;
    if (l == '0) return b;
    if (u) return p ? b + 32'd4 : b;
    return p ? b - span : b - span + 32'd4;
  endfunction

  task automatic run_op(logic [15:0] l, logic [31:0] b, logic [3:0] bi,
                        bit ld, bit u, bit p, bit w, bit s, bit rnd_ready);
    logic [15:0] rem = l;
    bit          empty = (l == '0);
    int          n_exp = empty ? 1 : $countones(l);
    int          k = 0;
    int          guard = 0;
    logic [31:0] wbv = exp_wb(l, b, u);
    logic [31:0] a_exp = exp_first(l, b, u, p);
    bit          stalled = 1'b0;
    logic [31:0] st_addr = '0;
    for (int i = 0; i < 16; i++) rf[i] = $urandom;
    @(negedge clk);
    reg_list = l; base = b; base_idx = bi; load = ld; up = u; pre = p;
    wb = w; psr = s; pc = {$urandom, 2'b00}[31:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (k < n_exp && guard < 400) begin
      mem_ready = rnd_ready ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      if (stalled) begin
        chk(mem_req && mem_addr == st_addr, "R12 stall hold", mem_addr, st_addr);
        stalled = 1'b0;
      end
      if (mem_req && mem_ready) begin
        int r = 15;
        logic [31:0] d_exp;
        for (int i = 15; i >= 0; i--) if (rem[i]) r = i;
        rem[r] = 1'b0;
        chk(mem_addr == a_exp, "R1/R2 address", mem_addr, a_exp);
        chk(mem_seq == (k != 0), "R8 seq tag", 32'(mem_seq), 32'(k != 0));
        chk(mem_we == !ld, "R1 write enable", 32'(mem_we), 32'(!ld));
        if (!ld) begin
          if (r == 15) d_exp = pc + 32'd12;
          else if (r == int'(bi)) d_exp = (k == 0) ? b : wbv;
          else d_exp = rf[r];
          chk(mem_wdata == d_exp, empty ? "R7 empty store" :
              (r == 15 ? "R6 pc store" : (r == int'(bi) ? "R5 base store" : "R1 store data")),
              mem_wdata, d_exp);
          chk(!rf_we, "R1 no rf write on store", 32'(rf_we), 0);
        end else begin
          d_exp = a_exp ^ RD_KEY;
          if (empty) d_exp[1:0] = 2'b00;
          chk(rf_we && rf_waddr == 4'(r), "R1 load target", 32'(rf_waddr), 32'(r));
          chk(rf_wdata == d_exp, empty ? "R7 empty load" : "R1 load data", rf_wdata, d_exp);
        end
        chk(psr_restore == (ld && s && !empty && r == 15), "R9 restore strobe",
            32'(psr_restore), 32'(ld && s && !empty && r == 15));
        a_exp += 32'd4;
        k++;
      end else begin
        chk(!psr_restore, "R9 no strobe idle", 32'(psr_restore), 0);
        if (mem_req) begin
          stalled = 1'b1;
          st_addr = mem_addr;
        end
      end
      @(negedge clk);
      guard++;
    end
    mem_ready = 1'b0;
    #1;
    chk(done && !mem_req, "R10 done after last", 32'(done), 1);
    if (w && !(ld && l[bi])) begin
      chk(wb_valid && wb_value == wbv, empty ? "R7 empty writeback" : "R3 writeback",
          wb_value, wbv);
    end else begin
      chk(!wb_valid, ld && l[bi] ? "R4 wb suppressed" : "R3 no wb", 32'(wb_valid), 0);
    end
    @(negedge clk);
    #1;
    chk(!done && !busy, "R10 done single pulse", 32'(done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2 + 1);
    chk(!busy && !mem_req && !done, "R11 reset state", {busy, mem_req, done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // directed corner cases
    run_op(16'h00F0, 32'h0000_1000, 4'd2, 0, 1, 0, 1, 0, 1); // up/post store
    run_op(16'h0C03, 32'h0000_2000, 4'd5, 1, 1, 1, 1, 0, 1); // up/pre load
    run_op(16'h0C03, 32'h0000_3000, 4'd5, 0, 0, 1, 1, 0, 1); // down/pre store
    run_op(16'h8101, 32'h0000_4000, 4'd6, 1, 0, 0, 1, 0, 1); // down/post load
    run_op(16'h0000, 32'h0000_5000, 4'd3, 1, 1, 0, 1, 0, 1); // R7 empty load
    run_op(16'h0000, 32'h0000_6000, 4'd3, 0, 0, 1, 1, 0, 0); // R7 empty store
    run_op(16'h0118, 32'h0000_7000, 4'd3, 0, 1, 1, 1, 0, 1); // R5 base first
    run_op(16'h0118, 32'h0000_8000, 4'd8, 0, 0, 0, 1, 0, 1); // R5 base not first
    run_op(16'h0118, 32'h0000_9000, 4'd4, 1, 1, 0, 1, 0, 1); // R4 base loaded
    run_op(16'h8006, 32'h0000_A000, 4'd0, 1, 1, 1, 1, 1, 1); // R9 restore
    run_op(16'h8006, 32'h0000_B000, 4'd0, 0, 1, 0, 0, 1, 1); // R6 pc store, R9 none
    run_op(16'hFFFF, 32'h0000_C000, 4'd7, 0, 0, 1, 1, 0, 0); // full list
    for (int n = 0; n < 40; n++) begin
      logic [15:0] l = 16'($urandom);
      if (n % 7 == 0) l = '0;
      run_op(l, {$urandom, 2'b00}[31:0], 4'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom), 1'b1);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule